// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block runs frame transmission from four transmit descriptor slots that are held in on-chip registers, not in memory. Each slot has three words: a buffer word, a length word and a status word. The buffer word carries the frame buffer address in its upper bits and control flags in its low nibble. Software arms a slot by writing an address with the enable flag set. The engine visits the slots in strict ring order. For each armed slot it asks a byte-stream fetch port for the slot's buffer and length. It then waits for the transmitter to report completion, records the outcome in the slot, and moves to the next slot.

Software sees all twelve descriptor words through a plain register port. Reads are combinational and writes take effect on the clock edge. The buffer word of slot 0 also returns the engine's current ring position, so that after a reset a driver can line up its head and tail pointers with the hardware. Each completed frame produces a one-cycle done pulse. A level interrupt stays pending until software clears a done flag somewhere in the ring.

Top module: `tx_desc_ring`

## Requirements
- R1: The ring has four slots. The current slot index starts at 0 after reset, steps by one on each completed frame and wraps from 3 to 0. It reads back in bits [3:2] of slot 0's buffer word. Those bits read as 0 in the other slots.
- R2: Register address bits [3:2] select the slot and bits [1:0] select the word: 0 is the buffer word, 1 is the length, 2 is the status. The buffer word holds the address in bits [31:4], the done flag in bit 1 and the enable flag in bit 0. After reset every word reads 0.
- R3: The fetch port is the only output that starts a transfer. The engine raises the fetch request only for a slot whose enable flag is set. The request carries the slot's address with the low four bits zero and the slot's length. Request, address and length hold steady until the acknowledge.
- R4: When the current slot is not armed, the engine waits on that slot. It issues no request and does not move its index, even if later slots are armed.
- R5: On the completion report, the engine sets the slot's done flag, clears its enable flag, stores the status and advances the index.
- R6: Status bits [4:0] record, in order: aborted, jabber timeout, underrun, no carrier, loss of carrier. Bit 5 marks a real abort. In full duplex it is aborted AND (jabber OR underrun). In half duplex it is simply aborted.
- R7: The done pulse is high for exactly the one cycle in which a completion is accepted, once per frame.
- R8: The interrupt pending level rises the cycle after a completion. It falls the cycle after software writes a buffer word whose done flag was 1 with bit 1 at 0. If both happen in the same cycle, it stays set.
- R9: Writing a buffer word with the low four bits zero makes the slot idle: enable and done both read 0. The new address is kept.
- R10: While the transmit-enable input is low, no new slot is started. A frame already in flight still completes.
- R11: The length is 11 bits wide. Higher written bits are dropped and read back as 0. The engine requests exactly the stored length.
- R12: If software writes the buffer word of the slot that is completing, in the same cycle, the address comes from the write, but the done flag ends up 1 and the enable flag ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| macTxEn | input | 1 | Transmit enable from the MAC control register |
| fullDuplex | input | 1 | Link duplex, used to qualify a real abort |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address: slot in [3:2], word in [1:0] |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| fetchReq | output | 1 | Buffer fetch request |
| fetchAddr | output | 32 | Buffer start address |
| fetchLen | output | 11 | Byte count to fetch |
| fetchAck | input | 1 | Fetch request accepted |
| txDone | input | 1 | Transmitter reports the frame finished |
| txStatus | input | 5 | Completion status, valid with txDone |
| donePulse | output | 1 | One-cycle pulse per completed frame |
| irqPending | output | 1 | Done interrupt level |

## Verification
Two things can land on the same clock edge: a frame completing and software writing a buffer word. The bench creates this on purpose by raising the completion report in the same cycle as a register write. In one case the write clears a done flag in another slot. The pending level must then stay high, because a new completion wins over a clear. In the other case the write re-arms the very slot that is completing. That slot must then show the written address together with done set and enable clear. Randomized frames then run the ring through many wraps, with random lengths, status codes and duplex settings, and with pauses of the transmit enable.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int SLOT_CNT  = 4;
  localparam int IDX_W     = 2;
  localparam int FLAG_BITS = 4;
  localparam int STAT_W    = 5;

  // flag bits inside the buffer word
  localparam int BIT_EN   = 0;
  localparam int BIT_DONE = 1;

  // word selectors within a slot
  localparam logic [1:0] WORD_BUF  = 2'd0;
  localparam logic [1:0] WORD_LEN  = 2'd1;
  localparam logic [1:0] WORD_STAT = 2'd2;

  // completion status bit positions
  localparam int ST_ABORT = 0;
  localparam int ST_JAB   = 1;
  localparam int ST_UND   = 2;
  localparam int ST_NOCAR = 3;
  localparam int ST_LOSS  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } txrState_e;

  typedef struct packed {
    logic launch;
    logic complete;
  } txrStrobe_t;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       macTxEn,
  input  logic       curArmed,
  input  logic       fetchAck,
  input  logic       txDone,
  output txrStrobe_t strobe,
  output logic       fetchReq
);
  txrState_e state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe.launch   = 1'b0;
    strobe.complete = 1'b0;
    unique case (state)
      ST_IDLE: if (macTxEn && curArmed) begin
        strobe.launch = 1'b1;
        stateNext     = ST_REQ;
      end
      ST_REQ:  if (fetchAck) stateNext = ST_WAIT;
      ST_WAIT: if (txDone) begin
        strobe.complete = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign fetchReq = (state == ST_REQ);

  // R3: a request is held until it is accepted
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck |=> fetchReq);

  // R7: completion is a single-cycle event
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |=> !strobe.complete);

  // R10: idle engine with transmit disabled starts nothing
  a_r10_idle_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && !macTxEn |=> !fetchReq);
endmodule

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fullDuplex,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  txrStrobe_t        strobe,
  input  logic [STAT_W-1:0] txStatus,
  output logic              curArmed,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [LEN_W-1:0]  fetchLen,
  output logic              donePulse,
  output logic              irqPending
);
  localparam int BASE_W = ADDR_W - FLAG_BITS;
  localparam int SREC_W = STAT_W + 1;

  logic [BASE_W-1:0] bufBase  [SLOT_CNT];
  logic [LEN_W-1:0]  slotLen  [SLOT_CNT];
  logic [SREC_W-1:0] slotStat [SLOT_CNT];
  logic [SLOT_CNT-1:0] slotEn, slotDone;
  logic [IDX_W-1:0]  curIdx;
  logic [BASE_W-1:0] fetchBaseQ;
  logic [LEN_W-1:0]  fetchLenQ;

  logic [IDX_W-1:0]  wrSlot;
  logic [1:0]        wrWord;
  logic [SLOT_CNT-1:0] bufHit, lenHit, clrEvt;
  logic              abortReal;

  assign wrSlot = regAddr[3:2];
  assign wrWord = regAddr[1:0];

  generate
    for (genvar g = 0; g < SLOT_CNT; g++) begin : gSlotDecode
      assign bufHit[g] = regWr && (wrSlot == IDX_W'(g)) && (wrWord == WORD_BUF);
      assign lenHit[g] = regWr && (wrSlot == IDX_W'(g)) && (wrWord == WORD_LEN);
      assign clrEvt[g] = bufHit[g] && slotDone[g] && !regWdata[BIT_DONE];
    end
  endgenerate

  assign abortReal = txStatus[ST_ABORT] &
                     (fullDuplex ? (txStatus[ST_JAB] | txStatus[ST_UND]) : 1'b1);

  // descriptor storage: software write first, hardware completion last
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotEn   <= '0;
      slotDone <= '0;
      for (int i = 0; i < SLOT_CNT; i++) begin
        bufBase[i]  <= '0;
        slotLen[i]  <= '0;
        slotStat[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOT_CNT; i++) begin
        if (bufHit[i]) begin
          bufBase[i]  <= regWdata[ADDR_W-1:FLAG_BITS];
          slotEn[i]   <= regWdata[BIT_EN];
          slotDone[i] <= regWdata[BIT_DONE];
        end
        if (lenHit[i]) slotLen[i] <= regWdata[LEN_W-1:0];
        if (strobe.complete && (curIdx == IDX_W'(i))) begin
          slotEn[i]   <= 1'b0;
          slotDone[i] <= 1'b1;
          slotStat[i] <= {abortReal, txStatus};
        end
      end
    end
  end

  // ring position, interrupt level and launched-frame latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx     <= '0;
      irqPending <= 1'b0;
      fetchBaseQ <= '0;
      fetchLenQ  <= '0;
    end else begin
      if (strobe.complete) curIdx <= curIdx + 1'b1;
      if (strobe.complete)  irqPending <= 1'b1;
      else if (|clrEvt)     irqPending <= 1'b0;
      if (strobe.launch) begin
        fetchBaseQ <= bufBase[curIdx];
        fetchLenQ  <= slotLen[curIdx];
      end
    end
  end

  assign curArmed  = slotEn[curIdx];
  assign fetchAddr = {fetchBaseQ, {FLAG_BITS{1'b0}}};
  assign fetchLen  = fetchLenQ;
  assign donePulse = strobe.complete;

  always_comb begin
    logic [IDX_W-1:0] idxView;
    idxView  = (wrSlot == '0) ? curIdx : '0;
    regRdata = '0;
    unique case (wrWord)
      WORD_BUF:  regRdata = {bufBase[wrSlot], idxView, slotDone[wrSlot], slotEn[wrSlot]};
      WORD_LEN:  regRdata = {{(ADDR_W-LEN_W){1'b0}}, slotLen[wrSlot]};
      WORD_STAT: regRdata = {{(ADDR_W-SREC_W){1'b0}}, slotStat[wrSlot]};
      default:   regRdata = '0;
    endcase
  end

  // R1: index steps by one modulo four per completion
  a_r1_idx_advance: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |=> curIdx == IDX_W'($past(curIdx) + 1'b1));

  // R4: without a completion the ring position does not move
  a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.complete |=> $stable(curIdx));

  // R5: the finished slot shows done and is disarmed
  a_r5_done_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |=> slotDone[$past(curIdx)] && !slotEn[$past(curIdx)]);

  // R8: completion always leaves the interrupt pending
  a_r8_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |=> irqPending);
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              macTxEn,
  input  logic              fullDuplex,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [LEN_W-1:0]  fetchLen,
  input  logic              fetchAck,
  input  logic              txDone,
  input  logic [STAT_W-1:0] txStatus,
  output logic              donePulse,
  output logic              irqPending
);
  txrStrobe_t strobe;
  logic       curArmed;

  txr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .macTxEn  (macTxEn),
    .curArmed (curArmed),
    .fetchAck (fetchAck),
    .txDone   (txDone),
    .strobe   (strobe),
    .fetchReq (fetchReq)
  );

  txr_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fullDuplex (fullDuplex),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .strobe     (strobe),
    .txStatus   (txStatus),
    .curArmed   (curArmed),
    .fetchAddr  (fetchAddr),
    .fetchLen   (fetchLen),
    .donePulse  (donePulse),
    .irqPending (irqPending)
  );

  // R3: address and length are steady while a request waits
  a_r3_fetch_stable: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck |=> $stable(fetchAddr) && $stable(fetchLen));
endmodule

// File: tb/test_tx_desc_ring.sv
`timescale 1ns/1ps
module test_tx_desc_ring;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        macTxEn = 1'b0;
  logic        fullDuplex = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        fetchReq;
  logic [31:0] fetchAddr;
  logic [10:0] fetchLen;
  logic        fetchAck = 1'b0;
  logic        txDone = 1'b0;
  logic [4:0]  txStatus = '0;
  logic        donePulse;
  logic        irqPending;

  int checks = 0;
  int fails = 0;
  logic [1:0] expCur = 2'd0;

  always #4 clk = ~clk;   // 125 MHz

  tx_desc_ring i_tx_desc_ring (
    .clk(clk), .rstN(rstN), .macTxEn(macTxEn), .fullDuplex(fullDuplex),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchLen(fetchLen),
    .fetchAck(fetchAck), .txDone(txDone), .txStatus(txStatus),
    .donePulse(donePulse), .irqPending(irqPending)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] bufExp(input int slot, input logic [31:0] addr,
                                         input bit done, input bit en);
    logic [1:0] idx;
    idx = (slot == 0) ? expCur : 2'b00;
    return {addr[31:4], idx, done, en};
  endfunction

  function automatic logic [31:0] statExp(input logic [4:0] st, input bit fd);
    bit hard;
    hard = st[0] && (fd ? (st[1] || st[2]) : 1'b1);
    return {26'd0, hard, st};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // wait for a request, check it, accept it after a random delay
  task automatic reqAck(input logic [31:0] expAddr, input logic [10:0] expLen);
    bit got = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (fetchReq) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(got, "R3 request raised", {31'd0, fetchReq}, 32'd1);
    check(fetchAddr == {expAddr[31:4], 4'h0}, "R3 fetch address", fetchAddr,
          {expAddr[31:4], 4'h0});
    check(fetchLen == expLen, "R11 fetch length", {21'd0, fetchLen}, {21'd0, expLen});
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      check(fetchReq == 1'b1, "R3 request held", {31'd0, fetchReq}, 32'd1);
    end
    fetchAck = 1'b1;
    @(negedge clk);
    fetchAck = 1'b0;
    #1 check(fetchReq == 1'b0, "R3 request dropped after ack", {31'd0, fetchReq}, 32'd0);
  endtask

  task automatic finish(input logic [4:0] st, input bit fd);
    @(negedge clk);
    fullDuplex = fd; txStatus = st; txDone = 1'b1;
    #1 check(donePulse == 1'b1, "R7 done pulse high", {31'd0, donePulse}, 32'd1);
    @(negedge clk);
    txDone = 1'b0;
    expCur = expCur + 2'd1;
    #1 check(donePulse == 1'b0, "R7 done pulse single", {31'd0, donePulse}, 32'd0);
    check(irqPending == 1'b1, "R8 pending after completion", {31'd0, irqPending}, 32'd1);
  endtask

  task automatic checkSlot(input int s, input logic [31:0] addr, input bit done,
                           input bit en, input string req);
    logic [31:0] v;
    rd({s[1:0], 2'd0}, v);
    check(v == bufExp(s, addr, done, en), req, v, bufExp(s, addr, done, en));
  endtask

  task automatic checkStat(input int s, input logic [4:0] st, input bit fd);
    logic [31:0] v;
    rd({s[1:0], 2'd2}, v);
    check(v == statExp(st, fd), "R6 status word", v, statExp(st, fd));
  endtask

  logic [31:0] addrTab [4];

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'h0, v); check(v == 32'd0, "R2 reset buffer word", v, 32'd0);
    rd(4'h6, v); check(v == 32'd0, "R2 reset status word", v, 32'd0);
    check(irqPending == 1'b0, "R8 reset pending", {31'd0, irqPending}, 32'd0);
    check(fetchReq == 1'b0, "R3 reset no request", {31'd0, fetchReq}, 32'd0);

    // R11 length truncation
    wr(4'h5, 32'hFFFF_FFFF);
    rd(4'h5, v); check(v == 32'h7FF, "R11 length width", v, 32'h7FF);

    // R10 transmit disabled blocks a launch
    addrTab[0] = 32'h1000_0040;
    wr(4'h1, 32'd60);
    wr(4'h0, addrTab[0] | 32'h1);
    repeat (10) @(negedge clk);
    check(fetchReq == 1'b0, "R10 no launch while disabled", {31'd0, fetchReq}, 32'd0);
    macTxEn = 1'b1;
    reqAck(addrTab[0], 11'd60);
    finish(5'b00101, 1'b1);
    checkSlot(0, addrTab[0], 1'b1, 1'b0, "R5 slot0 done set enable cleared");
    checkStat(0, 5'b00101, 1'b1);

    // R4 unarmed slot1 blocks armed slot2
    addrTab[2] = 32'h2000_0100;
    wr(4'h9, 32'd100);
    wr(4'h8, addrTab[2] | 32'h1);
    repeat (10) @(negedge clk);
    check(fetchReq == 1'b0, "R4 waits on unarmed slot", {31'd0, fetchReq}, 32'd0);
    rd(4'h0, v); check(v[3:2] == 2'd1, "R4 index held at 1", {30'd0, v[3:2]}, 32'd1);

    // R9 and R8 clear: write zero low nibble to slot0
    addrTab[0] = 32'h1000_0080;
    wr(4'h0, addrTab[0]);
    check(irqPending == 1'b0, "R8 pending cleared by done clear", {31'd0, irqPending}, 32'd0);
    checkSlot(0, addrTab[0], 1'b0, 1'b0, "R9 slot0 idle after clear");
    addrTab[3] = 32'h3000_0000;
    wr(4'hC, addrTab[3] | 32'h1);
    wr(4'hC, addrTab[3]);
    checkSlot(3, addrTab[3], 1'b0, 1'b0, "R9 armed slot3 returned to idle");

    // slot1 then slot2, duplex rule both ways
    addrTab[1] = 32'h1800_0010;
    wr(4'h5, 32'd64);
    wr(4'h4, addrTab[1] | 32'h1);
    reqAck(addrTab[1], 11'd64);
    finish(5'b01001, 1'b1);
    checkStat(1, 5'b01001, 1'b1);
    reqAck(addrTab[2], 11'd100);
    finish(5'b01001, 1'b0);
    checkStat(2, 5'b01001, 1'b0);
    checkSlot(2, addrTab[2], 1'b1, 1'b0, "R5 slot2 done");

    // R8 same cycle: completion of slot3 with done clear of slot1
    wr(4'hD, 32'd70);
    wr(4'hC, addrTab[3] | 32'h1);
    reqAck(addrTab[3], 11'd70);
    @(negedge clk);
    txStatus = 5'd0; txDone = 1'b1;
    regWr = 1'b1; regAddr = 4'h4; regWdata = addrTab[1];
    @(negedge clk);
    txDone = 1'b0; regWr = 1'b0;
    expCur = expCur + 2'd1;
    #1 check(irqPending == 1'b1, "R8 set wins over clear", {31'd0, irqPending}, 32'd1);
    checkSlot(1, addrTab[1], 1'b0, 1'b0, "R8 slot1 done cleared");
    rd(4'h0, v); check(v[3:2] == 2'd0, "R1 index wrapped to 0", {30'd0, v[3:2]}, 32'd0);

    // R12 same cycle write to the completing slot
    wr(4'h1, 32'd33);
    wr(4'h0, addrTab[0] | 32'h1);
    reqAck(addrTab[0], 11'd33);
    @(negedge clk);
    txStatus = 5'b00011; fullDuplex = 1'b0; txDone = 1'b1;
    regWr = 1'b1; regAddr = 4'h0; regWdata = 32'h4444_0001;
    @(negedge clk);
    txDone = 1'b0; regWr = 1'b0;
    expCur = expCur + 2'd1;
    addrTab[0] = 32'h4444_0000;
    checkSlot(0, addrTab[0], 1'b1, 1'b0, "R12 completion wins flags");

    // clear all done flags
    for (int s = 0; s < 4; s++) wr({s[1:0], 2'd0}, addrTab[s]);
    check(irqPending == 1'b0, "R8 pending cleared", {31'd0, irqPending}, 32'd0);

    // randomized frames
    void'($urandom(32'd12345));
    for (int n = 0; n < 40; n++) begin
      int s;
      logic [31:0] a;
      logic [10:0] l;
      logic [4:0]  st;
      bit fd;
      s  = int'(expCur);
      a  = $urandom() & 32'hFFFF_FFF0;
      l  = 11'($urandom());
      st = 5'($urandom());
      fd = 1'($urandom());
      if ($urandom_range(0, 3) == 0) macTxEn = 1'b0;
      wr({s[1:0], 2'd1}, {21'd0, l});
      wr({s[1:0], 2'd0}, a | 32'h1);
      if (!macTxEn) begin
        repeat (4) @(negedge clk);
        check(fetchReq == 1'b0, "R10 paused ring idle", {31'd0, fetchReq}, 32'd0);
        macTxEn = 1'b1;
      end
      reqAck(a, l);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      finish(st, fd);
      checkStat(s, st, fd);
      checkSlot(s, a, 1'b1, 1'b0, "R5 random slot done");
      rd(4'h0, v);
      check(v[3:2] == expCur, "R1 random index", {30'd0, v[3:2]}, {30'd0, expCur});
      wr({s[1:0], 2'd0}, a);
      check(irqPending == 1'b0, "R8 random clear", {31'd0, irqPending}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule